// File: doc/BRIEF.md
# Shared Tick Counter with Core Halt Gating

This block keeps one free-running tick counter that several cores read as a common time base. Each core drives one halt status line. A software-written gating mask picks which cores may stop the count: while any core whose gating bit is set reports halted, the counter holds its value. Cores whose gating bit is clear may halt without any effect on the count.

Software reaches the block through a small command port. A command is a 4-bit code, an 8-bit parameter field that must be zero, and a data word. Results land in a readback register one clock after the command is taken. Four commands exist: read the gating mask, write the gating mask, read the lower half of the counter, and read the upper half. Reading the lower half also captures the upper half, so a later upper-half read completes the same counter value. A core normally joins the mask by reading it, setting its own bit and writing it back. None of these commands touches the count.

The counter is twice the readback width (64 bits by default). The number of cores is a parameter, four by default.

Top module: `shared_tick_counter`

## Requirements
- R1: The counter is 2*RB_W bits wide and resets to zero. On each clock edge where it is not frozen it increments by one. It wraps from all ones to zero.
- R2: The counter is frozen on an edge when, at that edge, halt_i[n] is 1 for some core n below NUM_CORES whose gating bit n is 1. A high halt_i[n] whose gating bit is 0 has no effect.
- R3: Reset clears the gating mask and the readback register to zero. With the mask all zero, the counter never freezes.
- R4: Code 2 (mask write) loads the full cmd_data word into the gating mask at the edge. The new mask gates from the next edge on. Mask bits at or above NUM_CORES are stored and read back but never gate. The readback register keeps its value.
- R5: Code 1 (mask read) loads the gating mask into the readback register, visible after the edge.
- R6: Code 3 (low read) loads the lower RB_W bits of the counter, as held before that edge's increment, into the readback register. At the same edge it captures the upper RB_W bits into a snapshot.
- R7: Code 4 (high read) loads the snapshot taken by the last low read, zero after reset. Counter movement since that low read does not change the result.
- R8: Mask reads and writes never change the counter's progress. The count stays equal to the number of unfrozen edges since reset.
- R9: A command is taken only when cmd_valid is 1 and cmd_param is zero. Any other code, a nonzero parameter field, or cmd_valid low changes neither the mask, the snapshot, the readback register nor the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_i | input | NUM_CORES | Halt status, one line per core |
| cmd_valid | input | 1 | Command strobe, one command per high cycle |
| cmd_code | input | 4 | Command code: 1 mask read, 2 mask write, 3 low read, 4 high read |
| cmd_param | input | 8 | Parameter field, must be zero for the command to be taken |
| cmd_data | input | RB_W | Data word for the mask write |
| rdback | output | RB_W | Readback register |

## Verification
The count itself is never visible directly, so any fault in it shows up as a wrong value on the next low read. One missed or extra increment stays in the count for good and shows on every later read. A wrong gating bit appears right after a mask read. It also shows as a count that drifts when a selected core halts, or that stalls when an unselected core halts. A snapshot taken at the wrong moment shows on the upper-half read that follows. This is most visible when the lower half wraps between the two reads. The bench therefore uses a narrow readback width so the wrap and the upper-half carry happen within the run.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [3:0] {
    STC_NOP     = 4'h0,
    STC_MASK_RD = 4'h1,
    STC_MASK_WR = 4'h2,
    STC_CNT_LO  = 4'h3,
    STC_CNT_HI  = 4'h4
  } stc_cmd_e;

  typedef struct packed {
    logic mask_rd;
    logic mask_wr;
    logic cnt_lo;
    logic cnt_hi;
  } stc_strobe_t;

  localparam int STC_CODE_W  = 4;
  localparam int STC_PARAM_W = 8;

endpackage

// File: rtl/stc_cmd_decode.sv
module stc_cmd_decode
  import stc_pkg::*;
(
  input  logic                   cmd_valid,
  input  logic [STC_CODE_W-1:0]  cmd_code,
  input  logic [STC_PARAM_W-1:0] cmd_param,
  output stc_strobe_t            strb
);

  logic     accept;
  stc_cmd_e code_e;

  assign accept = cmd_valid && (cmd_param == '0);
  assign code_e = stc_cmd_e'(cmd_code);

  always_comb begin
    strb = '0;
    if (accept) begin
      unique case (code_e)
        STC_MASK_RD: strb.mask_rd = 1'b1;
        STC_MASK_WR: strb.mask_wr = 1'b1;
        STC_CNT_LO:  strb.cnt_lo  = 1'b1;
        STC_CNT_HI:  strb.cnt_hi  = 1'b1;
        default:     strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/stc_halt_gate.sv
module stc_halt_gate #(
  parameter int NUM_CORES = 4,
  parameter int RB_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RB_W-1:0]      wr_val,
  input  logic [NUM_CORES-1:0] halt_i,
  output logic [RB_W-1:0]      mask_q,
  output logic                 frozen
);

  function automatic logic any_gated_halt(
    input logic [NUM_CORES-1:0] halts,
    input logic [NUM_CORES-1:0] sel
  );
    logic hit;
    hit = 1'b0;
    for (int n = 0; n < NUM_CORES; n++) begin
      hit = hit | (halts[n] & sel[n]);
    end
    return hit;
  endfunction

  logic [NUM_CORES-1:0] gate_bits;
  assign gate_bits = mask_q[NUM_CORES-1:0];
  assign frozen    = any_gated_halt(halt_i, gate_bits);

  always_ff @(posedge clk) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_val;
  end

endmodule

// File: rtl/stc_count.sv
module stc_count #(
  parameter int RB_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic              snap,
  output logic [2*RB_W-1:0] cnt_q,
  output logic [RB_W-1:0]   hi_snap_q
);

  localparam int CNT_W = 2 * RB_W;

  function automatic logic [CNT_W-1:0] bump(
    input logic [CNT_W-1:0] cur,
    input logic             hold
  );
    return hold ? cur : cur + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      hi_snap_q <= '0;
    end else begin
      cnt_q <= bump(cnt_q, frozen);
      if (snap) hi_snap_q <= cnt_q[CNT_W-1:RB_W];
    end
  end

endmodule

// File: rtl/stc_readback.sv
module stc_readback
  import stc_pkg::*;
#(
  parameter int RB_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  stc_strobe_t     strb,
  input  logic [RB_W-1:0] mask,
  input  logic [RB_W-1:0] cnt_lo,
  input  logic [RB_W-1:0] hi_snap,
  output logic [RB_W-1:0] rb_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)            rb_q <= '0;
    else if (strb.mask_rd) rb_q <= mask;
    else if (strb.cnt_lo)  rb_q <= cnt_lo;
    else if (strb.cnt_hi)  rb_q <= hi_snap;
  end

endmodule

// File: rtl/shared_tick_counter.sv
module shared_tick_counter
  import stc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int RB_W      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CORES-1:0] halt_i,
  input  logic                 cmd_valid,
  input  logic [3:0]           cmd_code,
  input  logic [7:0]           cmd_param,
  input  logic [RB_W-1:0]      cmd_data,
  output logic [RB_W-1:0]      rdback
);

  localparam int CNT_W = 2 * RB_W;

  stc_strobe_t       strb;
  logic [RB_W-1:0]   mask_q;
  logic              frozen;
  logic [CNT_W-1:0]  cnt_q;
  logic [RB_W-1:0]   hi_snap_q;

  stc_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_param (cmd_param),
    .strb      (strb)
  );

  stc_halt_gate #(.NUM_CORES(NUM_CORES), .RB_W(RB_W)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (strb.mask_wr),
    .wr_val (cmd_data),
    .halt_i (halt_i),
    .mask_q (mask_q),
    .frozen (frozen)
  );

  stc_count #(.RB_W(RB_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .frozen    (frozen),
    .snap      (strb.cnt_lo),
    .cnt_q     (cnt_q),
    .hi_snap_q (hi_snap_q)
  );

  stc_readback #(.RB_W(RB_W)) u_rb (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .mask    (mask_q),
    .cnt_lo  (cnt_q[RB_W-1:0]),
    .hi_snap (hi_snap_q),
    .rb_q    (rdback)
  );

endmodule

// File: rtl/stc_checker.sv
module stc_checker
  import stc_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int RB_W      = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] halt_i,
  input stc_strobe_t          strb,
  input logic [RB_W-1:0]      cmd_data,
  input logic [RB_W-1:0]      mask_q,
  input logic                 frozen,
  input logic [2*RB_W-1:0]    cnt_q,
  input logic [RB_W-1:0]      hi_snap_q,
  input logic [RB_W-1:0]      rdback
);

  assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen |=> cnt_q == $past(cnt_q) + 1'b1);

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(cnt_q));

  assert_freeze_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (halt_i & mask_q[NUM_CORES-1:0]) != '0);

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mask_wr |=> mask_q == $past(cmd_data));

  assert_mask_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.mask_wr |=> $stable(mask_q));

  assert_mask_rb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.mask_rd |=> rdback == $past(mask_q));

  assert_low_rb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cnt_lo |=> rdback == $past(cnt_q[RB_W-1:0]));

  assert_snap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cnt_lo |=> hi_snap_q == $past(cnt_q[2*RB_W-1:RB_W]));

  assert_high_rb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cnt_hi |=> rdback == $past(hi_snap_q));

  assert_rb_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.mask_wr || strb == '0) |=> $stable(rdback));

endmodule

bind shared_tick_counter stc_checker #(.NUM_CORES(NUM_CORES), .RB_W(RB_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halt_i    (halt_i),
  .strb      (strb),
  .cmd_data  (cmd_data),
  .mask_q    (mask_q),
  .frozen    (frozen),
  .cnt_q     (cnt_q),
  .hi_snap_q (hi_snap_q),
  .rdback    (rdback)
);

// File: tb/sim_shared_tick_counter.sv
`timescale 1ns/1ps
module sim_shared_tick_counter;

  localparam int NC   = 4;
  localparam int RBW  = 8;
  localparam int CW   = 2 * RBW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NC-1:0]  halt_i = '0;
  logic           cmd_valid = 1'b0;
  logic [3:0]     cmd_code = '0;
  logic [7:0]     cmd_param = '0;
  logic [RBW-1:0] cmd_data = '0;
  logic [RBW-1:0] rdback;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  shared_tick_counter #(.NUM_CORES(NC), .RB_W(RBW)) u0 (
    .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .cmd_param(cmd_param), .cmd_data(cmd_data),
    .rdback(rdback)
  );

  // Reference model built from the requirements
  logic [CW-1:0]  m_cnt;
  logic [RBW-1:0] m_mask, m_snap, m_rb;

  function automatic bit exp_frozen(input logic [NC-1:0] h, input logic [RBW-1:0] m);
    for (int k = 0; k < NC; k++) if (h[k] && m[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [CW-1:0] exp_next(input logic [CW-1:0] c, input bit f);
    if (f) return c;
    return (c == {CW{1'b1}}) ? '0 : c + 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_mask <= '0; m_snap <= '0; m_rb <= '0;
    end else begin
      m_cnt <= exp_next(m_cnt, exp_frozen(halt_i, m_mask));
      if (cmd_valid && cmd_param == 8'd0) begin
        case (cmd_code)
          4'h1: m_rb <= m_mask;
          4'h2: m_mask <= cmd_data;
          4'h3: begin m_rb <= m_cnt[RBW-1:0]; m_snap <= m_cnt[CW-1:RBW]; end
          4'h4: m_rb <= m_snap;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req, input logic [RBW-1:0] act, input logic [RBW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] code, input logic [RBW-1:0] data, input logic [7:0] prm = 8'd0);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data; cmd_param = prm;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; cmd_data = '0; cmd_param = '0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    logic [RBW-1:0] lo_a, lo_b, hi_v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 readback after reset", rdback, '0);
    issue(4'h1, '0);
    check("R3 mask after reset", rdback, '0);
    issue(4'h4, '0);
    check("R7 snapshot zero after reset", rdback, '0);
    // R3: mask zero, halts have no effect
    halt_i = '1;
    repeat (6) @(negedge clk);
    issue(4'h3, '0);
    check("R3 no freeze with empty mask", rdback, m_rb);
    halt_i = '0;
    // R4/R5 mask write with upper bits, read back
    issue(4'h2, 8'hA4);
    check("R4 readback kept on mask write", rdback, m_rb);
    issue(4'h1, '0);
    check("R5 mask read", rdback, 8'hA4);
    // R2 selected core halted: count frozen
    halt_i = 4'b0100;
    @(negedge clk);
    issue(4'h3, '0); lo_a = rdback;
    repeat (5) @(negedge clk);
    issue(4'h3, '0); lo_b = rdback;
    check("R2 frozen by gated halt", lo_b, lo_a);
    // R2/R4 unselected core and high mask bits do not gate
    halt_i = 4'b1011;
    repeat (5) @(negedge clk);
    issue(4'h3, '0);
    check("R2 unselected halts ignored", rdback, m_rb);
    halt_i = '0;
    // R9 rejected commands
    issue(4'h2, 8'h0F, 8'h01);
    issue(4'h7, 8'hFF);
    issue(4'h1, '0);
    check("R9 nonzero param and bad code ignored", rdback, 8'hA4);
    issue(4'h3, '0, 8'h80);
    check("R9 rejected read keeps readback", rdback, 8'hA4);
    // Random mixed phase, R8 via count consistency
    for (int i = 0; i < 3000; i++) begin
      halt_i = NC'($urandom);
      case ($urandom_range(0, 7))
        0: issue(4'h2, RBW'($urandom));
        1: begin issue(4'h1, '0); check("R5 random mask read", rdback, m_rb); end
        2: begin issue(4'h3, '0); check("R8 random low read", rdback, m_rb); end
        3: begin issue(4'h4, '0); check("R7 random high read", rdback, m_rb); end
        4: issue(4'($urandom_range(5, 15)), RBW'($urandom));
        default: @(negedge clk);
      endcase
    end
    // R6/R7 across a low-half wrap
    halt_i = '0;
    issue(4'h2, '0);
    while (m_cnt[RBW-1:0] != 8'hFF) @(negedge clk);
    hi_v = m_cnt[CW-1:RBW];
    issue(4'h3, '0);
    check("R6 low read at carry", rdback, 8'hFF);
    issue(4'h4, '0);
    check("R7 high matches snapshot despite carry", rdback, hi_v);
    // R1 full wrap of the counter
    while (m_cnt != {CW{1'b1}}) @(negedge clk);
    @(negedge clk);
    issue(4'h3, '0);
    check("R1 wrap low", rdback, 8'h00);
    issue(4'h4, '0);
    check("R1 wrap high", rdback, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule